// File: doc/BRIEF.md
# Segment-Aware Address Translation and Fault Unit

This unit turns a virtual address into a physical address for one access per clock. It first works out the processor's privilege level from a status word. It then checks whether the address sits in one of the two unmapped kernel windows. An address in either window is translated by stripping the top three bits.

Every other address is a mapped address. For these the unit forms a virtual page number and presents it, with the current address-space identifier, to an external page-table lookup port. The lookup returns, in the same cycle, a hit flag, a page-size shift, an offset mask, and a valid bit, dirty bit and frame number for each of the two pages the entry covers. From these the unit picks the even or odd page and checks it. It then either composes the physical address or reports one of several fault kinds.

Each fault carries the data an exception handler needs to refill or repair the mapping. The response is registered and appears one cycle after the request. The lookup port itself is combinational.

Top module: `xlat_unit`

## Requirements
- R1: The privilege level is decoded from `status` as follows. It is kernel (code 0) when `status & 0x10000006` is nonzero or `status[4:3]` is 0. Otherwise `status[4:3]` of 1 gives supervisor (1), 2 gives user (2) and 3 gives the illegal code (3). The decoded level is returned on `rspMode`.
- R2: An address with `vaddr[31:29]` = 3'b100 maps to `{3'b000, vaddr[28:0]}`. It raises an address-error fault if the level is not kernel or the access is misaligned. The fault code is 1 for a fetch and 2 for a load or store.
- R3: An address with `vaddr[31:29]` = 3'b101 maps to `{3'b000, vaddr[28:0]}` and never faults, whatever the level or alignment.
- R4: An access is misaligned when `vaddr & ((1<<accSize)-1)` is nonzero, where `accSize` is log2 of the byte count. A misaligned mapped access raises address-error code 1 (fetch) or 2 (data), whatever the lookup returns.
- R5: For mapped addresses, `lkVpn` equals `vaddr[31:11]`, with its two low bits forced to zero unless `smallPages` is 1. `lkAsid` equals `asid`.
- R6: A mapped lookup miss raises refill code 3 for a fetch and code 4 for a load or store.
- R7: On a hit, `vaddr[lkShift]` selects the odd page (1) or the even page (0). If the selected valid bit is clear, the unit raises invalid code 5 for a fetch and code 6 for a load or store.
- R8: A store (`accKind` = 2) to a valid selected page whose dirty bit is clear raises modified code 7. Loads (`accKind` = 1) and fetches (`accKind` = 0) ignore the dirty bit.
- R9: A successful mapped translation returns `((frame >> (lkShift-12)) << lkShift) | (vaddr & lkOffMask)`. Here `frame` is the selected page's frame number and `lkShift` is at least 12.
- R10: On any fault `rspPaddr` is 0 and `rspBadVaddr` equals `vaddr`. On codes 3 to 7 the other payload fields are set as follows: `rspVpn2` = `lkVpn >> 2`, `rspVpn2x` = `lkVpn[1:0]` and `rspAsid` = `asid`. Otherwise these three fields are 0. All four payload fields are 0 when there is no fault.
- R11: `rspUncached` is 1 exactly when the access does not fault and `vaddr[31]` and `vaddr[29]` are both 1.
- R12: All response fields are registered. `rspValid` is 1 in the cycle after a cycle with `reqValid` high, and 0 otherwise. After reset every response output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| vaddr | input | 32 | Virtual address |
| accSize | input | 2 | log2 of access size in bytes |
| accKind | input | 2 | 0 fetch, 1 load, 2 store |
| asid | input | 8 | Current address-space identifier |
| status | input | 32 | Processor status word |
| smallPages | input | 1 | Keep the two low page-number bits |
| lkVpn | output | 21 | Page number to the lookup port |
| lkAsid | output | 8 | Identifier to the lookup port |
| lkHit | input | 1 | Lookup found a matching entry |
| lkShift | input | 5 | Entry page-size shift (at least 12) |
| lkValid0 | input | 1 | Even page valid |
| lkValid1 | input | 1 | Odd page valid |
| lkDirty0 | input | 1 | Even page writable |
| lkDirty1 | input | 1 | Odd page writable |
| lkPfn0 | input | 20 | Even page frame number |
| lkPfn1 | input | 20 | Odd page frame number |
| lkOffMask | input | 32 | Entry offset mask |
| rspValid | output | 1 | Response present |
| rspPaddr | output | 32 | Physical address |
| rspUncached | output | 1 | Access bypasses the cache |
| rspFault | output | 3 | Fault code, 0 for none |
| rspMode | output | 2 | Decoded privilege level |
| rspBadVaddr | output | 32 | Faulting virtual address |
| rspVpn2 | output | 19 | Page-pair number of the fault |
| rspVpn2x | output | 2 | Low page-number bits of the fault |
| rspAsid | output | 8 | Identifier of the fault |

## Verification
Most internal errors here show up at the ports in the very next response, because every request is translated independently and nothing is carried between requests. Three examples follow.
- A wrong privilege decode shows up on `rspMode`. In the unmapped kernel window it also appears as a spurious or missing address error.
- A wrong page-half select or frame alignment corrupts the upper bits of `rspPaddr`.
- A wrong priority between misalignment and the lookup outcome shows up as a refill or invalid code where an address error was due.

The page number is also checked combinationally on `lkVpn`, in the same cycle as the request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W     = 32;
  localparam int ASID_W   = 8;
  localparam int PFN_W    = 20;
  localparam int SHIFT_W  = 5;
  localparam int PAGE_LSB = 11;
  localparam int VPN_W    = VA_W - PAGE_LSB;
  localparam int VPN2_W   = VPN_W - 2;
  localparam int MIN_SHIFT = 12;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'd0,
    MODE_SUPER  = 2'd1,
    MODE_USER   = 2'd2,
    MODE_BAD    = 2'd3
  } opMode_t;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    FLT_NONE          = 3'd0,
    FLT_ADDR_FETCH    = 3'd1,
    FLT_ADDR_DATA     = 3'd2,
    FLT_REFILL_FETCH  = 3'd3,
    FLT_REFILL_DATA   = 3'd4,
    FLT_INVALID_FETCH = 3'd5,
    FLT_INVALID_DATA  = 3'd6,
    FLT_MODIFIED      = 3'd7
  } fault_t;

  typedef struct packed {
    logic    capture;
    logic    direct;
    logic    oddHalf;
    logic    tlbFault;
    logic    addrFault;
    logic    uncached;
    fault_t  code;
    opMode_t mode;
  } strobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic               reqValid,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [1:0]         accSize,
  input  accKind_t           kind,
  input  logic [VA_W-1:0]    status,
  input  logic               lkHit,
  input  logic [SHIFT_W-1:0] lkShift,
  input  logic               lkValid0,
  input  logic               lkValid1,
  input  logic               lkDirty0,
  input  logic               lkDirty1,
  output strobe_t            stb
);
  localparam logic [VA_W-1:0] KERNEL_FORCE = 32'h1000_0006;

  opMode_t curMode;
  logic    inWin0, inWin1, misAligned, isData, isStore;
  logic    oddSel, halfValid, halfDirty;
  logic [2:0] lowMask;
  fault_t  code;

  always_comb begin
    if (|(status & KERNEL_FORCE) || status[4:3] == 2'b00) curMode = MODE_KERNEL;
    else if (status[4:3] == 2'b01)                        curMode = MODE_SUPER;
    else if (status[4:3] == 2'b10)                        curMode = MODE_USER;
    else                                                  curMode = MODE_BAD;
  end

  always_comb begin
    case (accSize)
      2'd0:    lowMask = 3'b000;
      2'd1:    lowMask = 3'b001;
      2'd2:    lowMask = 3'b011;
      default: lowMask = 3'b111;
    endcase
  end

  assign misAligned = |(vaddr[2:0] & lowMask);
  assign inWin0     = (vaddr[VA_W-1 -: 3] == 3'b100);
  assign inWin1     = (vaddr[VA_W-1 -: 3] == 3'b101);
  assign isData     = (kind != KIND_FETCH);
  assign isStore    = (kind == KIND_STORE);
  assign oddSel     = vaddr[lkShift];
  assign halfValid  = oddSel ? lkValid1 : lkValid0;
  assign halfDirty  = oddSel ? lkDirty1 : lkDirty0;

  always_comb begin
    code = FLT_NONE;
    if (inWin0) begin
      if (curMode != MODE_KERNEL || misAligned)
        code = isData ? FLT_ADDR_DATA : FLT_ADDR_FETCH;
    end else if (!inWin1) begin
      if (misAligned)              code = isData ? FLT_ADDR_DATA : FLT_ADDR_FETCH;
      else if (!lkHit)             code = isData ? FLT_REFILL_DATA : FLT_REFILL_FETCH;
      else if (!halfValid)         code = isData ? FLT_INVALID_DATA : FLT_INVALID_FETCH;
      else if (isStore && !halfDirty) code = FLT_MODIFIED;
    end
  end

  always_comb begin
    stb.capture   = reqValid;
    stb.direct    = inWin0 | inWin1;
    stb.oddHalf   = oddSel;
    stb.code      = code;
    stb.mode      = curMode;
    stb.addrFault = (code == FLT_ADDR_FETCH) || (code == FLT_ADDR_DATA);
    stb.tlbFault  = (code != FLT_NONE) && !stb.addrFault;
    stb.uncached  = (code == FLT_NONE) && vaddr[VA_W-1] && vaddr[VA_W-3];
  end
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [ASID_W-1:0]  asid,
  input  logic               smallPages,
  input  logic [SHIFT_W-1:0] lkShift,
  input  logic [PFN_W-1:0]   lkPfn0,
  input  logic [PFN_W-1:0]   lkPfn1,
  input  logic [VA_W-1:0]    lkOffMask,
  output logic [VPN_W-1:0]   lkVpn,
  output logic [ASID_W-1:0]  lkAsid,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspPaddr,
  output logic               rspUncached,
  output fault_t             rspFault,
  output opMode_t            rspMode,
  output logic [VA_W-1:0]    rspBadVaddr,
  output logic [VPN2_W-1:0]  rspVpn2,
  output logic [1:0]         rspVpn2x,
  output logic [ASID_W-1:0]  rspAsid
);
  logic [VPN_W-1:0] vpnRaw;
  logic [PFN_W-1:0] pfnSel;
  logic [VA_W-1:0]  mappedPa, directPa, paNext;
  logic             anyFault;

  assign vpnRaw   = vaddr[VA_W-1:PAGE_LSB];
  assign lkVpn    = smallPages ? vpnRaw : {vpnRaw[VPN_W-1:2], 2'b00};
  assign lkAsid   = asid;
  assign pfnSel   = stb.oddHalf ? lkPfn1 : lkPfn0;
  assign mappedPa = ((VA_W'(pfnSel) >> (lkShift - SHIFT_W'(MIN_SHIFT))) << lkShift)
                    | (vaddr & lkOffMask);
  assign directPa = {3'b000, vaddr[VA_W-4:0]};
  assign anyFault = stb.tlbFault | stb.addrFault;
  assign paNext   = anyFault ? '0 : (stb.direct ? directPa : mappedPa);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspPaddr    <= '0;
      rspUncached <= 1'b0;
      rspFault    <= FLT_NONE;
      rspMode     <= MODE_KERNEL;
      rspBadVaddr <= '0;
      rspVpn2     <= '0;
      rspVpn2x    <= '0;
      rspAsid     <= '0;
    end else begin
      rspValid <= stb.capture;
      if (stb.capture) begin
        rspPaddr    <= paNext;
        rspUncached <= stb.uncached;
        rspFault    <= stb.code;
        rspMode     <= stb.mode;
        rspBadVaddr <= anyFault ? vaddr : '0;
        rspVpn2     <= stb.tlbFault ? lkVpn[VPN_W-1:2] : '0;
        rspVpn2x    <= stb.tlbFault ? lkVpn[1:0] : 2'b00;
        rspAsid     <= stb.tlbFault ? asid : '0;
      end
    end
  end

  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> rspValid);

  assert_direct_top_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(stb.direct)) |-> (rspPaddr[VA_W-1 -: 3] == 3'b000));

  assert_uncached_no_fault_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspUncached |-> (rspFault == FLT_NONE));

  assert_vpn2x_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault inside {FLT_REFILL_FETCH, FLT_REFILL_DATA, FLT_INVALID_FETCH,
     FLT_INVALID_DATA, FLT_MODIFIED} && !$past(smallPages)) |-> (rspVpn2x == 2'b00));
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [31:0]         vaddr,
  input  logic [1:0]          accSize,
  input  logic [1:0]          accKind,
  input  logic [7:0]          asid,
  input  logic [31:0]         status,
  input  logic                smallPages,
  output logic [20:0]         lkVpn,
  output logic [7:0]          lkAsid,
  input  logic                lkHit,
  input  logic [4:0]          lkShift,
  input  logic                lkValid0,
  input  logic                lkValid1,
  input  logic                lkDirty0,
  input  logic                lkDirty1,
  input  logic [19:0]         lkPfn0,
  input  logic [19:0]         lkPfn1,
  input  logic [31:0]         lkOffMask,
  output logic                rspValid,
  output logic [31:0]         rspPaddr,
  output logic                rspUncached,
  output logic [2:0]          rspFault,
  output logic [1:0]          rspMode,
  output logic [31:0]         rspBadVaddr,
  output logic [18:0]         rspVpn2,
  output logic [1:0]          rspVpn2x,
  output logic [7:0]          rspAsid
);
  strobe_t stb;
  fault_t  faultQ;
  opMode_t modeQ;

  xlat_ctrl u_ctrl (
    .reqValid (reqValid),
    .vaddr    (vaddr),
    .accSize  (accSize),
    .kind     (accKind_t'(accKind)),
    .status   (status),
    .lkHit    (lkHit),
    .lkShift  (lkShift),
    .lkValid0 (lkValid0),
    .lkValid1 (lkValid1),
    .lkDirty0 (lkDirty0),
    .lkDirty1 (lkDirty1),
    .stb      (stb)
  );

  xlat_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .vaddr       (vaddr),
    .asid        (asid),
    .smallPages  (smallPages),
    .lkShift     (lkShift),
    .lkPfn0      (lkPfn0),
    .lkPfn1      (lkPfn1),
    .lkOffMask   (lkOffMask),
    .lkVpn       (lkVpn),
    .lkAsid      (lkAsid),
    .rspValid    (rspValid),
    .rspPaddr    (rspPaddr),
    .rspUncached (rspUncached),
    .rspFault    (faultQ),
    .rspMode     (modeQ),
    .rspBadVaddr (rspBadVaddr),
    .rspVpn2     (rspVpn2),
    .rspVpn2x    (rspVpn2x),
    .rspAsid     (rspAsid)
  );

  assign rspFault = faultQ;
  assign rspMode  = modeQ;

  assert_modified_store_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultQ == FLT_MODIFIED) |-> ($past(accKind) == 2'd2));

  assert_fault_payload_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && faultQ != FLT_NONE) |-> (rspBadVaddr == $past(vaddr)));
endmodule

// File: tb/xlat_unit_tb.sv
`timescale 1ns/1ps
module xlat_unit_tb;
  localparam int CLK_NS = 20;
  localparam logic [19:0] PFN_EVEN = 20'h00123;
  localparam logic [19:0] PFN_ODD  = 20'h00456;
  localparam logic [7:0]  ASID_V   = 8'h5A;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  sz;
    logic [1:0]  kind;
    logic [31:0] st;
    logic        sp;
    logic        hit;
    logic [4:0]  sh;
    logic        v0, v1, d0, d1;
    logic [31:0] om;
    logic [2:0]  code;
    logic [31:0] pa;
    logic        unc;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // R2 kernel fetch in window 0
    '{32'h8000_1234, 2'd2, 2'd0, 32'h0, 1'b0, 1'b0, 5'd12, 1'b0,1'b0,1'b0,1'b0, 32'hFFF, 3'd0, 32'h0000_1234, 1'b0},
    // R2 user load in window 0 -> data address error
    '{32'h8000_1234, 2'd2, 2'd1, 32'h10, 1'b0, 1'b0, 5'd12, 1'b0,1'b0,1'b0,1'b0, 32'hFFF, 3'd2, 32'h0, 1'b0},
    // R1 R2 illegal level fetch -> fetch address error
    '{32'h8000_1234, 2'd2, 2'd0, 32'h18, 1'b0, 1'b0, 5'd12, 1'b0,1'b0,1'b0,1'b0, 32'hFFF, 3'd1, 32'h0, 1'b0},
    // R1 user bits with forcing bit -> kernel
    '{32'h8000_1234, 2'd2, 2'd1, 32'h12, 1'b0, 1'b0, 5'd12, 1'b0,1'b0,1'b0,1'b0, 32'hFFF, 3'd0, 32'h0000_1234, 1'b0},
    // R2 R4 kernel misaligned in window 0
    '{32'h8000_1235, 2'd1, 2'd1, 32'h0, 1'b0, 1'b0, 5'd12, 1'b0,1'b0,1'b0,1'b0, 32'hFFF, 3'd2, 32'h0, 1'b0},
    // R3 R11 window 1, user, misaligned store: no fault, uncached
    '{32'hA000_0101, 2'd2, 2'd2, 32'h10, 1'b0, 1'b0, 5'd12, 1'b0,1'b0,1'b0,1'b0, 32'hFFF, 3'd0, 32'h0000_0101, 1'b1},
    // R7 R9 odd half hit
    '{32'h0000_3ABC, 2'd0, 2'd1, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd0, 32'h0045_6ABC, 1'b0},
    // R5 same with small pages
    '{32'h0000_3ABC, 2'd0, 2'd1, 32'h0, 1'b1, 1'b1, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd0, 32'h0045_6ABC, 1'b0},
    // R6 fetch miss
    '{32'h0040_3800, 2'd2, 2'd0, 32'h0, 1'b0, 1'b0, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd3, 32'h0, 1'b0},
    // R6 load miss
    '{32'h0040_3800, 2'd2, 2'd1, 32'h0, 1'b0, 1'b0, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd4, 32'h0, 1'b0},
    // R7 even half invalid on load
    '{32'h0000_2000, 2'd2, 2'd1, 32'h0, 1'b0, 1'b1, 5'd12, 1'b0,1'b1,1'b1,1'b1, 32'hFFF, 3'd6, 32'h0, 1'b0},
    // R7 odd half invalid on fetch
    '{32'h0000_1000, 2'd2, 2'd0, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b0,1'b1,1'b1, 32'hFFF, 3'd5, 32'h0, 1'b0},
    // R8 store to clean page
    '{32'h0000_2010, 2'd2, 2'd2, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b0,1'b1, 32'hFFF, 3'd7, 32'h0, 1'b0},
    // R8 load to clean page ignores dirty
    '{32'h0000_2010, 2'd2, 2'd1, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b0,1'b1, 32'hFFF, 3'd0, 32'h0012_3010, 1'b0},
    // R8 store to dirty page
    '{32'h0000_2010, 2'd2, 2'd2, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd0, 32'h0012_3010, 1'b0},
    // R4 misaligned load beats a miss
    '{32'h0000_2001, 2'd1, 2'd1, 32'h0, 1'b0, 1'b0, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd2, 32'h0, 1'b0},
    // R4 misaligned fetch on a good hit
    '{32'h0000_2002, 2'd2, 2'd0, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd1, 32'h0, 1'b0},
    // R9 large page, shift 14
    '{32'h0000_6123, 2'd0, 2'd1, 32'h0, 1'b0, 1'b1, 5'd14, 1'b1,1'b1,1'b1,1'b1, 32'h3FFF, 3'd0, 32'h0045_6123, 1'b0},
    // R11 mapped uncached hit
    '{32'hE000_0000, 2'd2, 2'd1, 32'h0, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd0, 32'h0012_3000, 1'b1},
    // R11 mapped uncached region but miss: no uncached flag
    '{32'hE000_0000, 2'd2, 2'd1, 32'h0, 1'b0, 1'b0, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd4, 32'h0, 1'b0},
    // R1 supervisor store to dirty odd page
    '{32'h0000_5008, 2'd2, 2'd2, 32'h08, 1'b0, 1'b1, 5'd12, 1'b1,1'b1,1'b1,1'b1, 32'hFFF, 3'd0, 32'h0045_6008, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic reqValid;
  logic [31:0] vaddr;
  logic [1:0]  accSize, accKind;
  logic [7:0]  asid;
  logic [31:0] status;
  logic        smallPages;
  logic [20:0] lkVpn;
  logic [7:0]  lkAsid;
  logic        lkHit;
  logic [4:0]  lkShift;
  logic        lkValid0, lkValid1, lkDirty0, lkDirty1;
  logic [19:0] lkPfn0, lkPfn1;
  logic [31:0] lkOffMask;
  logic        rspValid, rspUncached;
  logic [31:0] rspPaddr, rspBadVaddr;
  logic [2:0]  rspFault;
  logic [1:0]  rspMode, rspVpn2x;
  logic [18:0] rspVpn2;
  logic [7:0]  rspAsid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  xlat_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr), .accSize(accSize),
    .accKind(accKind), .asid(asid), .status(status), .smallPages(smallPages),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .lkHit(lkHit), .lkShift(lkShift),
    .lkValid0(lkValid0), .lkValid1(lkValid1), .lkDirty0(lkDirty0), .lkDirty1(lkDirty1),
    .lkPfn0(lkPfn0), .lkPfn1(lkPfn1), .lkOffMask(lkOffMask),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspUncached(rspUncached),
    .rspFault(rspFault), .rspMode(rspMode), .rspBadVaddr(rspBadVaddr),
    .rspVpn2(rspVpn2), .rspVpn2x(rspVpn2x), .rspAsid(rspAsid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expMode(input logic [31:0] st);
    if ((st & 32'h1000_0006) != 0 || st[4:3] == 2'b00) return 2'd0;
    else if (st[4:3] == 2'b01) return 2'd1;
    else if (st[4:3] == 2'b10) return 2'd2;
    else return 2'd3;
  endfunction

  function automatic logic [20:0] expVpn(input logic [31:0] va, input logic sp);
    logic [20:0] v;
    v = va[31:11];
    if (!sp) v[1:0] = 2'b00;
    return v;
  endfunction

  function automatic string tagOf(input vec_t t);
    if (t.va[31:29] == 3'b100) return "R2";
    if (t.va[31:29] == 3'b101) return "R3";
    case (t.code)
      3'd1, 3'd2: return "R4";
      3'd3, 3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      3'd7:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; vaddr = '0; accSize = '0; accKind = '0;
    asid = ASID_V; status = '0; smallPages = 1'b0; lkHit = 1'b0; lkShift = 5'd12;
    lkValid0 = 1'b0; lkValid1 = 1'b0; lkDirty0 = 1'b0; lkDirty1 = 1'b0;
    lkPfn0 = PFN_EVEN; lkPfn1 = PFN_ODD; lkOffMask = 32'hFFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(rspValid == 1'b0, "R12", "reset rspValid", 32'(rspValid), 32'h0);
    check(rspFault == 3'd0, "R12", "reset rspFault", 32'(rspFault), 32'h0);
    check(rspPaddr == 32'h0, "R12", "reset rspPaddr", rspPaddr, 32'h0);
    check(rspUncached == 1'b0, "R12", "reset rspUncached", 32'(rspUncached), 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      logic [31:0] expBad;
      logic [20:0] ev;
      t = VECS[i];
      reqValid = 1'b1; vaddr = t.va; accSize = t.sz; accKind = t.kind;
      status = t.st; smallPages = t.sp; lkHit = t.hit; lkShift = t.sh;
      lkValid0 = t.v0; lkValid1 = t.v1; lkDirty0 = t.d0; lkDirty1 = t.d1;
      lkOffMask = t.om;
      ev = expVpn(t.va, t.sp);
      #2;
      check(lkVpn == ev, "R5", "lkVpn", 32'(lkVpn), 32'(ev));
      check(lkAsid == ASID_V, "R5", "lkAsid", 32'(lkAsid), 32'(ASID_V));
      @(negedge clk);
      check(rspValid == 1'b1, "R12", "rspValid", 32'(rspValid), 32'h1);
      check(rspFault == t.code, tagOf(t), "fault", 32'(rspFault), 32'(t.code));
      check(rspPaddr == t.pa, tagOf(t), "paddr", rspPaddr, t.pa);
      check(rspUncached == t.unc, "R11", "uncached", 32'(rspUncached), 32'(t.unc));
      check(rspMode == expMode(t.st), "R1", "mode", 32'(rspMode), 32'(expMode(t.st)));
      expBad = (t.code != 3'd0) ? t.va : 32'h0;
      check(rspBadVaddr == expBad, "R10", "badVaddr", rspBadVaddr, expBad);
      if (t.code >= 3'd3) begin
        check(rspVpn2 == ev[20:2], "R10", "vpn2", 32'(rspVpn2), 32'(ev[20:2]));
        check(rspVpn2x == ev[1:0], "R10", "vpn2x", 32'(rspVpn2x), 32'(ev[1:0]));
        check(rspAsid == ASID_V, "R10", "asid", 32'(rspAsid), 32'(ASID_V));
      end else begin
        check(rspVpn2 == 19'h0, "R10", "vpn2 zero", 32'(rspVpn2), 32'h0);
        check(rspVpn2x == 2'b00, "R10", "vpn2x zero", 32'(rspVpn2x), 32'h0);
        check(rspAsid == 8'h0, "R10", "asid zero", 32'(rspAsid), 32'h0);
      end
    end

    // R12 idle cycle drops rspValid
    reqValid = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b0, "R12", "idle rspValid", 32'(rspValid), 32'h0);

    // R3 window 1 fetch under illegal level, misaligned: still no fault
    reqValid = 1'b1; vaddr = 32'hBFC0_0003; accSize = 2'd2; accKind = 2'd0;
    status = 32'h18; lkHit = 1'b0;
    @(negedge clk);
    check(rspFault == 3'd0, "R3", "window1 fault", 32'(rspFault), 32'h0);
    check(rspPaddr == 32'h1FC0_0003, "R3", "window1 paddr", rspPaddr, 32'h1FC0_0003);
    check(rspUncached == 1'b1, "R11", "window1 uncached", 32'(rspUncached), 32'h1);
    reqValid = 1'b0;
    @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule